// File: doc/BRIEF.md
# Prescaled Real-Time Timer

This block is a free-running real-time timer in the slow-clock domain. A 16-bit divider produces a periodic increment event, and that event advances a 32-bit time counter. A select bit can make the counter advance on an external once-per-second tick pulse instead of on the divider. The divider keeps running in that mode, but its events no longer reach the counter.

All control sits in one 32-bit mode word, written with a single-cycle strobe and always readable on `cfg_rdata`. The word holds:

- the divider period;
- two interrupt enables;
- a restart request;
- a stop control;
- the increment-source select.

A restart request never reads back as set.

Two sticky status flags feed one level interrupt:

- The increment flag records that the counter advanced.
- The alarm flag records that an increment made the counter equal to `alarm_value`.

Each flag is cleared by its own pulse input. All pins are plain control and status signals. Nothing flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rtimer_top`

## Requirements
- R1: After reset the mode word reads 0x00008000, the counter is 0, both flags are 0 and `irq` is 0.
- R2: Mode word layout: [15:0] divider value, bit 16 alarm interrupt enable, bit 17 increment interrupt enable, bit 18 restart request, bit 20 stop, bit 24 once-per-second source select. All other bits read as 0, and the mode word written on one edge governs the divider from the next edge on.
- R3: With a divider value v of 3 or more, the divider rolls over every v cycles, and the counter (source select 0) rises by exactly 1 on each roll-over. A value of 0 gives a period of 65536 cycles.
- R4: Divider values 1 and 2 behave as 3: one roll-over every three cycles.
- R5: A write with bit 18 set clears the counter and the divider on that same edge, and this takes priority over an increment. Bit 18 always reads back as 0.
- R6: While the stop bit is 1, the counter and the divider hold their values, and tick pulses and roll-overs have no effect. A restart still clears them.
- R7: With source select 1, the counter rises by 1 on each cycle in which `tick_1hz` is high and ignores divider roll-overs.
- R8: `inc_flag` sets on every counter increment and stays set until a `clr_inc` pulse. A clear wins over a set in the same cycle.
- R9: `alarm_flag` sets when an increment makes the counter equal to `alarm_value` and stays set until a `clr_alarm` pulse. A clear wins over a set in the same cycle.
- R10: `irq` is high exactly when (`inc_flag` and bit 17) or (`alarm_flag` and bit 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the mode word |
| cfg_wdata | input | 32 | Mode word write data |
| cfg_rdata | output | 32 | Current mode word |
| tick_1hz | input | 1 | Once-per-second tick, one cycle high per tick |
| alarm_value | input | 32 | Alarm compare value |
| clr_inc | input | 1 | Clears the increment flag |
| clr_alarm | input | 1 | Clears the alarm flag |
| count | output | 32 | Time counter |
| inc_flag | output | 1 | Sticky increment status |
| alarm_flag | output | 1 | Sticky alarm status |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `tick_1hz`, the clear pulses and `cfg_wr` are synchronous to `clk` and free of unknown values once reset is released. They also assume that `alarm_value` is stable, so that a match is judged against a single value. The stimulus drives every input on the falling edge. It keeps `alarm_value` fixed through each run and changes it only between runs. Ticks and clears are pseudo-random single-cycle pulses, including clears that land on the edge where a flag would set.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int MW          = 32;
  localparam int B_ALM_IE    = 16;
  localparam int B_INC_IE    = 17;
  localparam int B_RESTART   = 18;
  localparam int B_STOP      = 20;
  localparam int B_SRC_SEL   = 24;
  localparam logic [MW-1:0] MODE_RESET = 32'h0000_8000;
  localparam logic [MW-1:0] MODE_KEEP  = 32'h0113_FFFF;

  typedef struct packed {
    logic        src_sel;
    logic        stop;
    logic        inc_ie;
    logic        alm_ie;
    logic [15:0] div_val;
  } mode_t;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] div_val,
  output logic             roll
);
  localparam logic [PRE_W-1:0] MIN_LIM = PRE_W'(2);
  localparam logic [PRE_W-1:0] MIN_VAL = PRE_W'(3);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;
  logic             at_lim;

  always_comb begin
    if (div_val == '0)           lim = '1;
    else if (div_val < MIN_VAL)  lim = MIN_LIM;
    else                         lim = div_val - PRE_W'(1);
  end

  assign at_lim = (div_q >= lim);
  assign roll   = run & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= at_lim ? '0 : div_q + PRE_W'(1);
  end
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             inc,
  input  logic [CNT_W-1:0] alarm_value,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] nxt;

  assign nxt = count + CNT_W'(1);
  assign hit = inc & ~restart & (nxt == alarm_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (inc)     count <= nxt;
  end
endmodule

// File: rtl/rt_flags.sv
module rt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic hit,
  input  logic clr_inc,
  input  logic clr_alarm,
  output logic inc_flag,
  output logic alarm_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_flag   <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      if (clr_inc)        inc_flag <= 1'b0;
      else if (inc)       inc_flag <= 1'b1;
      if (clr_alarm)      alarm_flag <= 1'b0;
      else if (hit)       alarm_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rtimer_top.sv
module rtimer_top #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             tick_1hz,
  input  logic [CNT_W-1:0] alarm_value,
  input  logic             clr_inc,
  input  logic             clr_alarm,
  output logic [CNT_W-1:0] count,
  output logic             inc_flag,
  output logic             alarm_flag,
  output logic             irq
);
  import rt_pkg::*;

  logic [MW-1:0] mode_q;
  mode_t         md;
  logic          restart;
  logic          run;
  logic          roll;
  logic          inc_ev;
  logic          hit;
  logic          inc_cnt;

  assign restart = cfg_wr & cfg_wdata[B_RESTART];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_RESET;
    else if (cfg_wr) mode_q <= cfg_wdata & MODE_KEEP;
  end

  assign md.src_sel = mode_q[B_SRC_SEL];
  assign md.stop    = mode_q[B_STOP];
  assign md.inc_ie  = mode_q[B_INC_IE];
  assign md.alm_ie  = mode_q[B_ALM_IE];
  assign md.div_val = mode_q[15:0];
  assign cfg_rdata  = mode_q;

  assign run    = ~md.stop;
  assign inc_ev = run & (md.src_sel ? tick_1hz : roll);
  assign inc_cnt = inc_ev & ~restart;

  rt_prescaler #(.PRE_W(16)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
    .div_val(md.div_val), .roll(roll)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .inc(inc_ev),
    .alarm_value(alarm_value), .count(count), .hit(hit)
  );

  rt_flags u_flg (
    .clk(clk), .rst_n(rst_n), .inc(inc_cnt), .hit(hit),
    .clr_inc(clr_inc), .clr_alarm(clr_alarm),
    .inc_flag(inc_flag), .alarm_flag(alarm_flag)
  );

  assign irq = (inc_flag & md.inc_ie) | (alarm_flag & md.alm_ie);
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             stop,
  input logic             src_sel,
  input logic             rd_restart,
  input logic             tick_1hz,
  input logic             clr_inc,
  input logic             clr_alarm,
  input logic [CNT_W-1:0] count,
  input logic             inc_flag,
  input logic             alarm_flag,
  input logic             irq
);
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0)); // R5
  AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_restart); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !restart) |=> $stable(count)); // R6
  AST_SRC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !tick_1hz && !restart) |=> $stable(count)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R3
  AST_INC_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_inc |=> !inc_flag); // R8
  AST_ALM_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_alarm |=> !alarm_flag); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_flag && !alarm_flag) |-> !irq); // R10
endmodule

bind rtimer_top rtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .stop(md.stop),
  .src_sel(md.src_sel), .rd_restart(cfg_rdata[18]), .tick_1hz(tick_1hz),
  .clr_inc(clr_inc), .clr_alarm(clr_alarm), .count(count),
  .inc_flag(inc_flag), .alarm_flag(alarm_flag), .irq(irq)
);

// File: tb/test_rtimer_top.sv
`timescale 1ns/1ps
module test_rtimer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tick_1hz = 1'b0;
  logic [31:0] alarm_value = '0;
  logic        clr_inc = 1'b0;
  logic        clr_alarm = 1'b0;
  logic [31:0] count;
  logic        inc_flag, alarm_flag, irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int clr_pct = 0;
  int tick_pct = 0;

  // reference state
  longint m_mode = 64'h8000;
  longint m_div = 0;
  longint m_cnt = 0;
  bit     m_incf = 0;
  bit     m_almf = 0;

  always #4 clk = ~clk;

  rtimer_top i_rtimer_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick_1hz(tick_1hz), .alarm_value(alarm_value),
    .clr_inc(clr_inc), .clr_alarm(clr_alarm), .count(count),
    .inc_flag(inc_flag), .alarm_flag(alarm_flag), .irq(irq)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 64'h8000; m_div = 0; m_cnt = 0; m_incf = 0; m_almf = 0;
    end else begin
      longint v, per;
      bit rs, stp, sel, inc;
      rs  = cfg_wr && cfg_wdata[18];
      stp = m_mode[20];
      sel = m_mode[24];
      v   = m_mode & 64'hFFFF;
      per = (v == 0) ? 65536 : (v < 3) ? 3 : v;
      inc = 0;
      if (rs) begin
        m_div = 0; m_cnt = 0;
      end else if (!stp) begin
        bit rolled;
        rolled = (m_div >= per - 1);
        m_div = rolled ? 0 : m_div + 1;
        inc = sel ? tick_1hz : rolled;
        if (inc) m_cnt = (m_cnt + 1) & 64'hFFFF_FFFF;
      end
      if (clr_inc) m_incf = 0; else if (inc) m_incf = 1;
      if (clr_alarm) m_almf = 0;
      else if (inc && m_cnt == longint'(alarm_value)) m_almf = 1;
      if (cfg_wr) m_mode = longint'(cfg_wdata) & 64'h0113_FFFF;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R4/R5/R6/R7 count", longint'(count), m_cnt);
      chk("R8 inc_flag", longint'(inc_flag), longint'(m_incf));
      chk("R9 alarm_flag", longint'(alarm_flag), longint'(m_almf));
      chk("R10 irq", longint'(irq),
          longint'((m_incf && m_mode[17]) || (m_almf && m_mode[16])));
      chk("R2/R5 mode readback", longint'(cfg_rdata), m_mode);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_1hz  = ($urandom_range(99) < tick_pct);
      clr_inc   = ($urandom_range(99) < clr_pct);
      clr_alarm = ($urandom_range(99) < clr_pct);
    end
    @(negedge clk);
    tick_1hz = 0; clr_inc = 0; clr_alarm = 0;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", longint'(cfg_rdata), 64'h8000);
    chk("R1 reset count", longint'(count), 0);
    chk("R1 reset flags/irq", longint'({inc_flag, alarm_flag, irq}), 0);
    // R3 period 5 with increment interrupt
    wr(32'h0006_0005);
    run(40);
    clr_pct = 20; run(60); clr_pct = 0;
    // R9 alarm with enable, R8 clears
    alarm_value = 32'd6;
    wr(32'h0005_0004);
    run(40);
    clr_pct = 30; run(80); clr_pct = 0;
    // R4 forbidden values
    wr(32'h0004_0001); run(30);
    wr(32'h0004_0002); run(30);
    // R5 restart mid-period
    wr(32'h0000_000A); run(27);
    wr(32'h0004_000A); run(25);
    // R6 stop holds, ticks ignored
    tick_pct = 50;
    wr(32'h0010_0007); run(40);
    wr(32'h0000_0007); run(30);
    // R7 once-per-second source
    wr(32'h0107_0003); run(100);
    alarm_value = 32'd20;
    clr_pct = 10; run(100); clr_pct = 0;
    wr(32'h0110_0003); run(20);
    tick_pct = 0;
    // R2 every bit written
    wr(32'hFFFF_FFFF); run(10);
    // R3 full-length period from value 0
    alarm_value = 32'd2;
    wr(32'h0005_0000); run(131100);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule